// File: doc/BRIEF.md
# External Interrupt Aggregator

This block collects up to 32 asynchronous interrupt lines from the rest of the chip and merges them into one interrupt request for the processor. The trigger type of each channel is fixed when the block is built. A channel can be level-sensitive or edge-sensitive. Its polarity selects either high level or rising edge, or low level or falling edge. Every line passes through a two-flop synchroniser before it is used, so any line can come from any clock domain or from a pin.

Software works with three 32-bit word registers. The enable register masks channels. The pending register shows which channels have fired, and writing a 0 to a bit clears that channel if it is an edge channel. The source register returns the number of the lowest-numbered channel that is both enabled and pending, so the handler does not have to scan for it. Any enabled pending channel raises the single processor request. Choosing among sources is left to software.

Top module: `irq_gather_top`

## Requirements
- R1: After reset, the enable register, the pending register and the source register all read 0, and `cpu_irq_o` is low.
- R2: Register word 0 is the enable register and can be read and written. Bits for channels at or above `NUM_CH` read 0. Its value changes only on a write to word 0. Word 3 always reads 0.
- R3: On an edge channel (`TRIG_EDGE` bit = 1), an input transition toward the active polarity sets the channel's pending bit. Active polarity is a rising edge when the `TRIG_POL` bit is 1 and a falling edge when it is 0. The bit becomes visible after the third rising clock edge following the input change. It stays set after the input returns to idle.
- R4: Writing to register word 1 (pending) clears each edge channel whose write-data bit is 0. A write-data bit of 1 leaves that channel's pending bit unchanged.
- R5: On a level channel (`TRIG_EDGE` bit = 0), the pending bit follows the input being at the active level. Active level is high when the `TRIG_POL` bit is 1 and low when it is 0. The latency is the same three clock edges as in R3. Writes to the pending register do not affect a level channel.
- R6: A channel whose enable bit is 0 never sets its pending bit and never raises `cpu_irq_o`.
- R7: `cpu_irq_o` is high exactly when at least one channel has both its enable bit and its pending bit set.
- R8: Register word 2 (source) is read-only. Bit 31 is a valid flag. Bits 4:0 hold the lowest channel number whose enable and pending bits are both set. When no such channel exists, the whole word reads 0.
- R9: Writes to the source register have no effect. Input lines at or above `NUM_CH` never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32 | Raw interrupt lines, one per channel, asynchronous |
| reg_addr_i | input | 2 | Register word select: 0 enable, 1 pending, 2 source, 3 spare |
| reg_wr_i | input | 1 | Write strobe for the selected word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word, combinational |
| cpu_irq_o | output | 1 | Merged interrupt request to the processor |

## Verification
The bench sweeps every channel of an eight-channel build. The build mixes edge and level channels with both polarities. For each channel it checks the exact cycle in which the pending bit appears, whether the bit is sticky, and how it responds to a clearing write, both with the channel enabled and disabled. A design with one synchroniser stage too many or too few fails the latency check. A design that treats a level channel as sticky, or lets software clear it, reports a stale or missing pending bit. A design that latches events on a masked channel raises the request after disable. The bench then steps the enable mask through all 256 values while every channel is pending. This catches a source encoder that prefers the highest channel, and a request line that ignores the mask.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

  localparam int MAX_CH = 32;
  localparam int IDX_W  = $clog2(MAX_CH);

  typedef enum logic [1:0] {
    REG_ENABLE  = 2'd0,
    REG_PENDING = 2'd1,
    REG_SOURCE  = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } src_t;

  // Mask with the low n bits set (n may be 0..32).
  function automatic logic [MAX_CH-1:0] chan_mask(input int n);
    logic [MAX_CH:0] wide;
    wide = ({{MAX_CH{1'b0}}, 1'b1} << n) - 1'b1;
    return wide[MAX_CH-1:0];
  endfunction

  // Lowest set bit of v, scanned from the top so the last hit wins.
  function automatic src_t lowest_pending(input logic [MAX_CH-1:0] v);
    src_t r;
    r = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.valid = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction

  // Register image of the source word: valid in bit 31, index in the low bits.
  function automatic logic [31:0] pack_source(input src_t s);
    return {s.valid, {(31 - IDX_W){1'b0}}, s.idx};
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/irq_chan.sv
module irq_chan #(
  parameter bit IS_EDGE  = 1'b1,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic en_i,
  input  logic clr_i,
  output logic event_o,
  output logic pend_o
);

  logic active;
  logic prev_active_q;
  logic pend_q;
  logic set_req;

  assign active = ACT_HIGH ? lvl_i : ~lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_active_q <= 1'b0;
    else         prev_active_q <= active;
  end

  generate
    if (IS_EDGE) begin : g_edge
      assign event_o = active & ~prev_active_q;
      assign set_req = en_i & event_o;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pend_q <= 1'b0;
        else if (set_req) pend_q <= 1'b1;
        else if (clr_i)   pend_q <= 1'b0;
      end

      // R3
      edge_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && !clr_i) |=> pend_q);

      // R4
      edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && clr_i && !set_req) |=> !pend_q);
    end else begin : g_level
      assign event_o = active;
      assign set_req = en_i & active;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= set_req;
      end

      // R5
      level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q |-> $past(active && en_i));
    end
  endgenerate

  assign pend_o = pend_q;

  // R6
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !pend_q) |=> !pend_q);

endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_gather_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAX_CH-1:0] req_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);

  src_t pick;

  always_comb pick = lowest_pending(req_i);

  assign valid_o = pick.valid;
  assign idx_o   = pick.idx;

  // R8
  src_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[idx_o]);

  // R8
  src_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((req_i & ((32'd1 << idx_o) - 32'd1)) == '0));

  // R8
  src_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (req_i == '0));

endmodule

// File: rtl/irq_gather_top.sv
module irq_gather_top
  import irq_gather_pkg::*;
#(
  parameter int          NUM_CH    = 32,
  parameter logic [31:0] TRIG_EDGE = 32'hFFFF_FFFF,
  parameter logic [31:0] TRIG_POL  = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] irq_lines_i,
  input  logic [1:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        cpu_irq_o
);

  localparam logic [MAX_CH-1:0] CH_MASK = chan_mask(NUM_CH);

  logic [MAX_CH-1:0] lines_sync;
  logic [MAX_CH-1:0] en_q;
  logic [MAX_CH-1:0] pend;
  logic [MAX_CH-1:0] events;
  logic [MAX_CH-1:0] pend_en;
  logic [MAX_CH-1:0] clr_vec;
  logic              wr_enable;
  logic              wr_pending;
  logic              src_valid;
  logic [IDX_W-1:0]  src_idx;
  logic              unused_inputs;

  irq_sync #(.W(MAX_CH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_lines_i),
    .sync_o (lines_sync)
  );

  assign unused_inputs = ^(lines_sync & ~CH_MASK) ^ ^events;

  assign wr_enable  = reg_wr_i && (reg_sel_e'(reg_addr_i) == REG_ENABLE);
  assign wr_pending = reg_wr_i && (reg_sel_e'(reg_addr_i) == REG_PENDING);
  assign clr_vec    = wr_pending ? ~reg_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_enable) en_q <= reg_wdata_i & CH_MASK;
  end

  generate
    for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
      if (i < NUM_CH) begin : g_on
        irq_chan #(
          .IS_EDGE (TRIG_EDGE[i]),
          .ACT_HIGH(TRIG_POL[i])
        ) u_chan (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .lvl_i  (lines_sync[i]),
          .en_i   (en_q[i]),
          .clr_i  (clr_vec[i]),
          .event_o(events[i]),
          .pend_o (pend[i])
        );
      end else begin : g_off
        assign events[i] = 1'b0;
        assign pend[i]   = 1'b0;
      end
    end
  endgenerate

  assign pend_en   = pend & en_q;
  assign cpu_irq_o = |pend_en;

  irq_prio u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend_en),
    .valid_o(src_valid),
    .idx_o  (src_idx)
  );

  always_comb begin
    unique case (reg_sel_e'(reg_addr_i))
      REG_ENABLE:  reg_rdata_o = en_q;
      REG_PENDING: reg_rdata_o = pend;
      REG_SOURCE:  reg_rdata_o = pack_source('{valid: src_valid, idx: src_idx});
      default:     reg_rdata_o = '0;
    endcase
  end

  // R7
  irq_matches_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o == src_valid);

  // R2
  enable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_enable |=> $stable(en_q));

  // R9
  upper_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend | en_q) & ~CH_MASK) == '0);

endmodule

// File: tb/tb_irq_gather_top.sv
`timescale 1ns/1ps
module tb_irq_gather_top;

  localparam int          N    = 8;
  localparam logic [31:0] EDGE = 32'h0000_000F;
  localparam logic [31:0] POL  = 32'h0000_0055;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  logic [7:0]  act = 8'h00;
  logic [23:0] upper = '0;
  int vectors = 0;
  int miscmp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Active level of channel c equals its POL bit; idle is the opposite.
  assign lines = {upper, ~(act ^ POL[7:0])};

  irq_gather_top #(.NUM_CH(N), .TRIG_EDGE(EDGE), .TRIG_POL(POL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wrr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  // Expected source word: scan upward, stop at first set bit.
  function automatic logic [31:0] exp_src(input logic [31:0] v);
    int k = 0;
    while (k < 32 && !v[k]) k++;
    if (k == 32) return 32'h0;
    return 32'h8000_0000 + k;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog got=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(2'd0, d); chk("R1 enable", d, 0);
    rd(2'd1, d); chk("R1 pending", d, 0);
    rd(2'd2, d); chk("R1 source", d, 0);
    rd(2'd3, d); chk("R1 spare", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 enable register
    wrr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 enable all", d, 32'hFF);
    wrr(2'd0, 32'h0000_005A); rd(2'd0, d); chk("R2 enable pattern", d, 32'h5A);
    wrr(2'd3, 32'h1234_5678); rd(2'd0, d); chk("R2 enable kept", d, 32'h5A);
    rd(2'd3, d); chk("R2 spare", d, 0);

    // R9 source read-only and upper lines inert
    wrr(2'd0, 32'hFFFF_FFFF);
    wrr(2'd2, 32'h8000_001F); rd(2'd2, d); chk("R9 source write", d, 0);
    upper = 24'hFFFFFF; tick(5); upper = 24'h0; tick(5);
    rd(2'd1, d); chk("R9 upper pending", d, 0);
    chk("R9 upper irq", {31'b0, irq}, 0);

    // R3 R4 R5 R6 per-channel sweep
    for (int c = 0; c < N; c++) begin
      for (int en = 0; en < 2; en++) begin
        logic [31:0] bitc;
        logic [31:0] expv;
        bitc = 32'd1 << c;
        expv = en ? bitc : 32'd0;
        act = 8'h00;
        wrr(2'd0, en ? bitc : 32'd0);
        tick(4);
        wrr(2'd1, 32'h0);
        act[c] = 1'b1;
        tick(2);
        rd(2'd1, d); chk(EDGE[c] ? "R3 latency early" : "R5 latency early", d, 0);
        tick(1);
        rd(2'd1, d); chk(en ? (EDGE[c] ? "R3 set" : "R5 set") : "R6 masked pending", d, expv);
        chk(en ? "R7 irq on" : "R6 masked irq", {31'b0, irq}, en);
        rd(2'd2, d); chk("R8 source single", d, exp_src(expv));
        if (!EDGE[c] && en) begin
          wrr(2'd1, 32'h0);
          rd(2'd1, d); chk("R5 write ignored", d, expv);
        end
        act[c] = 1'b0;
        tick(4);
        rd(2'd1, d);
        chk(EDGE[c] ? "R3 sticky" : "R5 follow idle", d, EDGE[c] ? expv : 32'd0);
        if (EDGE[c] && en) begin
          wrr(2'd1, 32'hFFFF_FFFF);
          rd(2'd1, d); chk("R4 write one keeps", d, expv);
          wrr(2'd1, ~bitc);
          rd(2'd1, d); chk("R4 write zero clears", d, 0);
          chk("R4 irq after clear", {31'b0, irq}, 0);
        end
      end
    end

    // R7 R8 enable-mask sweep with every channel pending
    act = 8'h00;
    wrr(2'd0, 32'hFF);
    tick(4);
    wrr(2'd1, 32'h0);
    act = 8'hFF;
    tick(4);
    for (int m = 0; m < 256; m++) begin
      logic [31:0] ep;
      wrr(2'd0, m);
      tick(2);
      ep = 32'h0F | (m & 32'hF0);
      rd(2'd1, d); chk("R5 sweep pending", d, ep);
      rd(2'd2, d); chk("R8 sweep source", d, exp_src(ep & m));
      chk("R7 sweep irq", {31'b0, irq}, {31'b0, |(ep & m)});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule